// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns a 32-bit bus address and the attributes of the access into eight active-low chip-select lines. Each chip select owns a base register and a mask register, written and read back through a small register port. The upper sixteen address bits are compared against the base field. Every set bit of a per-select don't-care field removes one address bit from the comparison, so a region covers 2^(k+16) bytes, where k is the number of set don't-care bits. When the set bits are not contiguous, one chip select covers several separate regions.

A match that passes the address comparison is then filtered. Write protection blocks writes. Five access-space mask bits block particular kinds of access. When an alternate master such as DMA or an external master owns the bus, a per-select flag decides whether the four supervisor/user code/data masks still apply. Chip select 0 is the boot select: until its valid bit is set, it fires for every access. When several selects qualify, only the lowest-numbered one drives its line. The line is registered. It goes low one clock after the bus-start strobe and returns high one clock after the transfer-done strobe.

Top module: `cs_decoder`

## Requirements
- R1: Chip select n qualifies on address when, for every bit i of 0..15, bus_addr[16+i] equals base bit i, or don't-care bit i is set. Address bits 15:0 never take part in the comparison.
- R2: With base 0x0000 and don't-care 0x0008, a select matches 0x0000_0000–0x0000_FFFF and 0x0008_0000–0x0008_FFFF. It does not match 0x0001_0000, 0x0007_FFFF or 0x0009_0000.
- R3: When the write-protect flag (mask register bit 8) is set, a write (bus_write=1) never asserts that select, and no other output reports it. Reads still assert it.
- R4: bus_kind encodes the access as 0 supervisor code, 1 supervisor data, 2 user code, 3 user data, 4 CPU space/interrupt acknowledge. The matching block bits in the mask register are bit 4, bit 3, bit 2, bit 1 and bit 5. A set block bit keeps the select deasserted for that kind of access.
- R5: When bus_alt=1 and the select's alternate-master flag (mask register bit 6) is 0, the four block bits for supervisor/user code/data are ignored. The CPU-space block bit (bit 5) still applies. With the flag at 1, all five block bits apply to alternate-master accesses.
- R6: Chip selects 1..7 never assert while their valid bit (mask register bit 0) is clear. Reset clears every valid bit.
- R7: While chip select 0 is not valid, it asserts for every access, regardless of address, direction or kind.
- R8: The register port has these fields. cfg_sel=0 selects the base register, with the base in bits 31:16. cfg_sel=1 selects the mask register, with the don't-care field in bits 31:16 and the flags in bits 8 and 6..0. All other bits read as zero and ignore writes. An index of 8 or more ignores writes and reads as zero.
- R9: When several selects qualify, only the lowest-numbered one asserts, so cs_n has at most one low bit.
- R10: cs_n takes the decode result on the clock edge that samples bus_start. It then holds, even if the bus inputs change, until the edge that samples bus_done, when all lines return high.
- R11: During reset all chip-select lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Chip-select index for register access |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the mask register |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| bus_start | input | 1 | Start of a bus transfer; the decode is captured |
| bus_done | input | 1 | End of the transfer; chip selects release |
| bus_addr | input | 32 | Bus address |
| bus_write | input | 1 | 1 for a write access |
| bus_kind | input | 3 | Access space code (see R4) |
| bus_alt | input | 1 | 1 when an alternate master owns the bus |
| cs_n | output | 8 | Active-low chip-select outputs |

## Verification
The hardest situation to reach is one where the address comparison passes but a later gate decides the outcome. Examples are a CPU-space access from an alternate master that must stay blocked while the other four masks are overridden, and a lower-numbered select that is masked so that a higher-numbered overlapping select takes over. The stimulus programs two selects over the same region with different block bits. It then sweeps access kind and master ownership against that region and predicts which of the two, if any, wins. The boot phase is covered too: accesses that fall inside another valid select's range are issued before chip select 0 is made valid.

// File: rtl/cs_pkg.sv
package cs_pkg;

   // Access space codes presented on bus_kind
   typedef enum logic [2:0] {
      ACC_SUP_CODE  = 3'd0,
      ACC_SUP_DATA  = 3'd1,
      ACC_USR_CODE  = 3'd2,
      ACC_USR_DATA  = 3'd3,
      ACC_CPU_SPACE = 3'd4
   } acc_kind_e;

   // Flag bit positions inside the mask register
   localparam int unsigned FLG_VALID = 0;
   localparam int unsigned FLG_UD    = 1;
   localparam int unsigned FLG_UC    = 2;
   localparam int unsigned FLG_SD    = 3;
   localparam int unsigned FLG_SC    = 4;
   localparam int unsigned FLG_CPU   = 5;
   localparam int unsigned FLG_AM    = 6;
   localparam int unsigned FLG_WP    = 8;
   localparam int unsigned FLG_TOP   = 8;

   typedef struct packed {
      logic wp;
      logic am;
      logic cpu_m;
      logic sc_m;
      logic sd_m;
      logic uc_m;
      logic ud_m;
      logic valid;
   } cs_attr_t;

endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
   import cs_pkg::*;
#(
   parameter int unsigned NUM_CS  = 8,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned FIELD_W = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr,
   input  logic [IDX_W-1:0]                  idx,
   input  logic                              sel,
   input  logic [DATA_W-1:0]                 wdata,
   output logic [DATA_W-1:0]                 rdata,
   output logic [NUM_CS-1:0][FIELD_W-1:0]    base_o,
   output logic [NUM_CS-1:0][FIELD_W-1:0]    dcare_o,
   output cs_attr_t [NUM_CS-1:0]             attr_o
);

   localparam int unsigned FLD_LSB = DATA_W - FIELD_W;

   for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
      logic hit_idx;
      assign hit_idx = wr && (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_o[g]  <= '0;
            dcare_o[g] <= '0;
            attr_o[g]  <= '0;
         end else if (hit_idx) begin
            if (sel) begin
               dcare_o[g]       <= wdata[DATA_W-1 -: FIELD_W];
               attr_o[g].wp     <= wdata[FLG_WP];
               attr_o[g].am     <= wdata[FLG_AM];
               attr_o[g].cpu_m  <= wdata[FLG_CPU];
               attr_o[g].sc_m   <= wdata[FLG_SC];
               attr_o[g].sd_m   <= wdata[FLG_SD];
               attr_o[g].uc_m   <= wdata[FLG_UC];
               attr_o[g].ud_m   <= wdata[FLG_UD];
               attr_o[g].valid  <= wdata[FLG_VALID];
            end else begin
               base_o[g] <= wdata[DATA_W-1 -: FIELD_W];
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (idx == IDX_W'(i)) begin
            if (sel) begin
               rdata[DATA_W-1 -: FIELD_W] = dcare_o[i];
               rdata[FLG_WP]    = attr_o[i].wp;
               rdata[FLG_AM]    = attr_o[i].am;
               rdata[FLG_CPU]   = attr_o[i].cpu_m;
               rdata[FLG_SC]    = attr_o[i].sc_m;
               rdata[FLG_SD]    = attr_o[i].sd_m;
               rdata[FLG_UC]    = attr_o[i].uc_m;
               rdata[FLG_UD]    = attr_o[i].ud_m;
               rdata[FLG_VALID] = attr_o[i].valid;
            end else begin
               rdata[DATA_W-1 -: FIELD_W] = base_o[i];
            end
         end
      end
   end

   if (FLD_LSB <= FLG_TOP) begin : g_bad_layout
      $error("cs_regfile: DATA_W too small for field and flags");
   end

endmodule

// File: rtl/cs_match.sv
module cs_match
   import cs_pkg::*;
#(
   parameter int unsigned FIELD_W = 16,
   parameter bit          GLOBAL  = 1'b0
) (
   input  logic [FIELD_W-1:0] addr_hi,
   input  logic [FIELD_W-1:0] base,
   input  logic [FIELD_W-1:0] dcare,
   input  cs_attr_t           attr,
   input  logic               is_write,
   input  logic [2:0]         kind,
   input  logic               alt,
   output logic               hit
);

   logic addr_ok;
   logic user_ign;
   logic space_blk;
   logic wp_blk;
   logic qual;

   assign addr_ok  = ((addr_hi ^ base) & ~dcare) == '0;
   assign user_ign = alt & ~attr.am;
   assign wp_blk   = attr.wp & is_write;

   always_comb begin
      case (kind)
         ACC_SUP_CODE:  space_blk = attr.sc_m & ~user_ign;
         ACC_SUP_DATA:  space_blk = attr.sd_m & ~user_ign;
         ACC_USR_CODE:  space_blk = attr.uc_m & ~user_ign;
         ACC_USR_DATA:  space_blk = attr.ud_m & ~user_ign;
         ACC_CPU_SPACE: space_blk = attr.cpu_m;
         default:       space_blk = 1'b0;
      endcase
   end

   assign qual = addr_ok & ~space_blk & ~wp_blk;

   if (GLOBAL) begin : g_boot
      assign hit = attr.valid ? qual : 1'b1;
   end else begin : g_plain
      assign hit = attr.valid & qual;
   end

endmodule

// File: rtl/cs_prio.sv
module cs_prio #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);

   // isolate lowest set bit
   assign grant = req & (~req + N'(1));

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
   import cs_pkg::*;
#(
   parameter int unsigned NUM_CS  = 8,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned FIELD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              bus_start,
   input  logic              bus_done,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_write,
   input  logic [2:0]        bus_kind,
   input  logic              bus_alt,
   output logic [NUM_CS-1:0] cs_n
);

   localparam int unsigned MAX_CS = 1 << IDX_W;

   if (NUM_CS < 1 || NUM_CS > MAX_CS) begin : g_bad_count
      $error("cs_decoder: NUM_CS does not fit the index width");
   end
   if (FIELD_W > ADDR_W) begin : g_bad_field
      $error("cs_decoder: FIELD_W exceeds ADDR_W");
   end

   logic [NUM_CS-1:0][FIELD_W-1:0] base_w;
   logic [NUM_CS-1:0][FIELD_W-1:0] dcare_w;
   cs_attr_t [NUM_CS-1:0]          attr_w;
   logic [NUM_CS-1:0]              hit_w;
   logic [NUM_CS-1:0]              grant_w;
   logic [FIELD_W-1:0]             addr_hi;

   assign addr_hi = bus_addr[ADDR_W-1 -: FIELD_W];

   cs_regfile #(
      .NUM_CS (NUM_CS),
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W),
      .FIELD_W(FIELD_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (cfg_wr),
      .idx    (cfg_idx),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .rdata  (cfg_rdata),
      .base_o (base_w),
      .dcare_o(dcare_w),
      .attr_o (attr_w)
   );

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      cs_match #(
         .FIELD_W(FIELD_W),
         .GLOBAL (g == 0)
      ) u_match (
         .addr_hi (addr_hi),
         .base    (base_w[g]),
         .dcare   (dcare_w[g]),
         .attr    (attr_w[g]),
         .is_write(bus_write),
         .kind    (bus_kind),
         .alt     (bus_alt),
         .hit     (hit_w[g])
      );
   end

   cs_prio #(.N(NUM_CS)) u_prio (
      .req  (hit_w),
      .grant(grant_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n <= '1;
      end else if (bus_start) begin
         cs_n <= ~grant_w;
      end else if (bus_done) begin
         cs_n <= '1;
      end
   end

endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk #(
   parameter int unsigned NUM_CS = 8,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [IDX_W-1:0]  cfg_idx,
   input logic              cfg_sel,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              bus_start,
   input logic              bus_done,
   input logic [NUM_CS-1:0] cs_n
);

   // shadow of the valid flags, tracked from the register port
   logic [NUM_CS-1:0] vshadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vshadow <= '0;
      end else if (cfg_wr && cfg_sel) begin
         for (int i = 0; i < NUM_CS; i++) begin
            if (cfg_idx == IDX_W'(i)) vshadow[i] <= cfg_wdata[0];
         end
      end
   end

   a_r9_onehot_out: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_start && !bus_done) |=> $stable(cs_n));

   a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_done && !bus_start) |=> (&cs_n));

   a_r6_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> (((~cs_n) & ~($past(vshadow) | NUM_CS'(1))) == '0));

   a_r7_boot_select: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start && !vshadow[0]) |=> !cs_n[0]);

endmodule

bind cs_decoder cs_decoder_chk #(
   .NUM_CS(NUM_CS),
   .IDX_W (IDX_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_wr   (cfg_wr),
   .cfg_idx  (cfg_idx),
   .cfg_sel  (cfg_sel),
   .cfg_wdata(cfg_wdata),
   .bus_start(bus_start),
   .bus_done (bus_done),
   .cs_n     (cs_n)
);

// File: tb/cs_decoder_test.sv
`timescale 1ns/1ps
module cs_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        bus_start = 1'b0;
   logic        bus_done = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_write = 1'b0;
   logic [2:0]  bus_kind = 3'd0;
   logic        bus_alt = 1'b0;
   logic [7:0]  cs_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cs_decoder uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .bus_start(bus_start), .bus_done(bus_done), .bus_addr(bus_addr),
      .bus_write(bus_write), .bus_kind(bus_kind), .bus_alt(bus_alt),
      .cs_n(cs_n)
   );

   // scoreboard
   logic [7:0] q_exp[$];
   string      q_tag[$];
   logic       launched_q = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) launched_q <= bus_start;

   always @(negedge clk) begin
      if (launched_q) begin
         if (q_exp.size() == 0) begin
            check("R10 unexpected launch", {24'h0, cs_n}, 32'hFFFF_FFFF);
         end else begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(t, {24'h0, cs_n}, {24'h0, ~e});
         end
      end
   end

   task automatic wr_reg(input logic [3:0] idx, input logic sel, input logic [31:0] d);
      @(negedge clk);
      cfg_idx = idx; cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] idx, input logic sel, input logic [31:0] exp, input string tag);
      @(negedge clk);
      cfg_idx = idx; cfg_sel = sel;
      #1;
      check(tag, cfg_rdata, exp);
   endtask

   // exp is the active-high one-hot of the select expected to fire
   task automatic access(input logic [31:0] a, input logic w, input logic [2:0] k,
                         input logic alt, input logic [7:0] exp, input string tag);
      @(negedge clk);
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      bus_addr = a; bus_write = w; bus_kind = k; bus_alt = alt; bus_start = 1'b1;
      @(negedge clk);
      bus_start = 1'b0;
      bus_addr = ~a; bus_write = ~w; bus_kind = 3'd4; bus_alt = ~alt;
      repeat (2) @(negedge clk);
      check({"R10 hold ", tag}, {24'h0, cs_n}, {24'h0, ~exp});
      bus_done = 1'b1;
      @(negedge clk);
      bus_done = 1'b0;
      check({"R10 release ", tag}, {24'h0, cs_n}, 32'h0000_00FF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R11 reset lines high", {24'h0, cs_n}, 32'h0000_00FF);
      rd_chk(4'd0, 1'b1, 32'h0, "R6 reset clears valid");
      @(negedge clk);
      rst_n = 1'b1;

      // boot select
      access(32'h1234_5678, 1'b0, 3'd3, 1'b0, 8'h01, "R7 boot read");
      access(32'hABCD_0000, 1'b1, 3'd4, 1'b1, 8'h01, "R7 boot write cpu alt");
      wr_reg(4'd1, 1'b0, 32'h0000_0000);
      wr_reg(4'd1, 1'b1, 32'h0008_0001);
      access(32'h0000_0000, 1'b0, 3'd3, 1'b0, 8'h01, "R9 boot cs0 beats cs1");

      // make cs0 a plain select
      wr_reg(4'd0, 1'b0, 32'hFF00_0000);
      wr_reg(4'd0, 1'b1, 32'h0000_0001);
      access(32'hFF00_1234, 1'b0, 3'd0, 1'b0, 8'h01, "R1 cs0 match");
      access(32'hFE00_0000, 1'b0, 3'd0, 1'b0, 8'h00, "R1 cs0 miss");
      access(32'hFF01_0000, 1'b0, 3'd3, 1'b0, 8'h00, "R1 cs0 low bit miss");

      // two-region example on cs1
      access(32'h0000_0000, 1'b0, 3'd3, 1'b0, 8'h02, "R2 region A low");
      access(32'h0000_FFFF, 1'b0, 3'd3, 1'b0, 8'h02, "R2 region A high");
      access(32'h0001_0000, 1'b0, 3'd3, 1'b0, 8'h00, "R2 above A");
      access(32'h0007_FFFF, 1'b0, 3'd3, 1'b0, 8'h00, "R2 below B");
      access(32'h0008_0000, 1'b0, 3'd3, 1'b0, 8'h02, "R2 region B low");
      access(32'h0008_FFFF, 1'b0, 3'd3, 1'b0, 8'h02, "R2 region B high");
      access(32'h0009_0000, 1'b0, 3'd3, 1'b0, 8'h00, "R2 above B");

      // write protect on cs2
      wr_reg(4'd2, 1'b0, 32'h1000_0000);
      wr_reg(4'd2, 1'b1, 32'h000F_0101);
      access(32'h1003_0000, 1'b0, 3'd1, 1'b0, 8'h04, "R3 read allowed");
      access(32'h1003_0000, 1'b1, 3'd1, 1'b0, 8'h00, "R3 write blocked");

      // space masks: cs3 blocks cpu+sc with am=0, cs5 overlaps unmasked
      wr_reg(4'd3, 1'b0, 32'h2000_0000);
      wr_reg(4'd3, 1'b1, 32'h0000_0031);
      wr_reg(4'd5, 1'b0, 32'h2000_0000);
      wr_reg(4'd5, 1'b1, 32'h0000_0001);
      access(32'h2000_0010, 1'b0, 3'd3, 1'b0, 8'h08, "R4 user data passes");
      access(32'h2000_0010, 1'b0, 3'd0, 1'b0, 8'h20, "R4 sup code masked, R9 next wins");
      access(32'h2000_0010, 1'b0, 3'd4, 1'b0, 8'h20, "R4 cpu space masked");
      access(32'h2000_0010, 1'b0, 3'd0, 1'b1, 8'h08, "R5 alt ignores sc mask");
      access(32'h2000_0010, 1'b0, 3'd4, 1'b1, 8'h20, "R5 alt keeps cpu mask");

      // cs4 with am=1 and sd mask
      wr_reg(4'd4, 1'b0, 32'h3000_0000);
      wr_reg(4'd4, 1'b1, 32'h0000_0049);
      access(32'h3000_0000, 1'b0, 3'd1, 1'b1, 8'h00, "R5 am=1 keeps sd mask");
      access(32'h3000_0000, 1'b0, 3'd1, 1'b0, 8'h00, "R4 sd mask");
      access(32'h3000_0000, 1'b0, 3'd2, 1'b1, 8'h10, "R4 user code passes");

      // valid bit on cs6
      wr_reg(4'd6, 1'b0, 32'h4000_0000);
      access(32'h4000_0000, 1'b0, 3'd3, 1'b0, 8'h00, "R6 invalid silent");
      wr_reg(4'd6, 1'b1, 32'h0000_0001);
      access(32'h4000_0000, 1'b0, 3'd3, 1'b0, 8'h40, "R6 valid fires");

      // register port layout
      rd_chk(4'd2, 1'b1, 32'h000F_0101, "R8 mask readback");
      wr_reg(4'd7, 1'b1, 32'hFFFF_FFFF);
      rd_chk(4'd7, 1'b1, 32'hFFFF_017F, "R8 reserved bits zero");
      wr_reg(4'd7, 1'b0, 32'hABCD_1234);
      rd_chk(4'd7, 1'b0, 32'hABCD_0000, "R8 base low bits zero");
      wr_reg(4'd9, 1'b0, 32'hFFFF_FFFF);
      rd_chk(4'd9, 1'b0, 32'h0, "R8 out of range reads zero");
      rd_chk(4'd0, 1'b0, 32'hFF00_0000, "R8 out of range write ignored");
      wr_reg(4'd7, 1'b1, 32'hFFFF_0001);
      access(32'h7777_0000, 1'b1, 3'd2, 1'b0, 8'h80, "R1 all dont-care");
      access(32'h2000_0000, 1'b0, 3'd3, 1'b0, 8'h08, "R9 lowest of three");

      repeat (3) @(negedge clk);
      check("R10 scoreboard drained", q_exp.size(), 32'd0);
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule